// File: doc/BRIEF.md
# Debug-Aware Peripheral Freeze Controller

This block generates one freeze enable for each of eight on-chip timing peripherals. A frozen peripheral stops counting until it is released. Software programs the freezes through a small register bus. One address sets freeze bits and another clears them, so that a single write never disturbs bits it does not name. A third address holds a debug configuration bit. A fourth address sets and clears bits in the same write.

Two inputs from the rest of the chip also act on the outputs. The first is the processor's debug-halt indication. While the processor is halted and the debug configuration bit is 1, every peripheral is frozen. The watchdog is frozen during any halt, whatever the configuration. The second is the watchdog's mode select. In reset mode the watchdog must not be stopped by software, so a programmed watchdog freeze only takes effect while that input is 0.

The register bus is a plain single-cycle control port with no handshake. A write is taken on every rising clock edge where `reg_wr` is high. Read data is a combinational function of `reg_addr` and needs no strobe. The freeze vector is combinational from the programmed state and the two chip inputs.

Top module: `periph_freeze_ctrl`

## Requirements
- R1: After reset the programmed freeze state is 0x00 and the debug configuration bit is 1. With `dbg_halt` low, `freeze` is 0x00.
- R2: A write to address 0 sets each programmed bit i for which wdata[i] is 1. Bits written 0 keep their value.
- R3: A write to address 1 clears each programmed bit i for which wdata[i] is 1. Bits written 0 keep their value.
- R4: Reading address 0 or address 1 returns the programmed state in bits 7:0 and zero above. Reading address 2 returns the debug configuration bit in bit 0 and zero above. Reading address 3 returns the state in both bits 7:0 and bits 15:8.
- R5: A write to address 3 clears the bits named in wdata[15:8] and sets the bits named in wdata[7:0] in the same cycle. Where both name a bit, the bit ends up set.
- R6: While `dbg_halt` is 1 and the configuration bit is 1, all eight freeze outputs are 1.
- R7: While `dbg_halt` is 1 and the configuration bit is 0, every output except the watchdog (bit 3) equals its programmed bit.
- R8: While `dbg_halt` is 1, freeze bit 3 (watchdog) is 1 for any programmed state, configuration bit or mode input.
- R9: While `dbg_halt` is 0, freeze bit 3 is 1 exactly when programmed bit 3 is 1 and `wdog_rst_mode` is 0.
- R10: While `dbg_halt` is 0, every output except bit 3 equals its programmed bit, whatever the value of `wdog_rst_mode`. The bit order is: 0 wakeup timer, 1 timer0, 2 radio clock, 3 watchdog, 4 USB, 5 DMA, 6 timer1, 7 timer2.
- R11: A write to address 2 loads the configuration bit from wdata[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | 2 | Register address (0 set, 1 clear, 2 config, 3 set+clear) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| dbg_halt | input | 1 | Processor halted in debug |
| wdog_rst_mode | input | 1 | Watchdog in reset mode; blocks a programmed watchdog freeze |
| freeze | output | 8 | Per-peripheral freeze enables |

## Verification
The bench loads each of the 256 programmed states. For each state it tries all eight combinations of halt, configuration bit and watchdog mode. The watchdog bit and the other seven bits are compared separately, so halt forcing, configuration gating and mode gating can each be told apart. A second sweep runs combined set-and-clear writes over many start states and mask pairs, including masks that overlap. This separates set-wins from clear-wins and shows whether bits named in neither mask are preserved. Directed writes of all-zero masks to the set and clear addresses show that zeros leave the state unchanged.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int PF_NUM  = 8;
  localparam int PF_WDOG = 3;
  localparam int PF_DW   = 16;
  localparam int PF_AW   = 2;

  // register addresses
  typedef enum logic [PF_AW-1:0] {
    PF_A_SET  = 2'd0,
    PF_A_CLR  = 2'd1,
    PF_A_CFG  = 2'd2,
    PF_A_BOTH = 2'd3
  } pf_addr_e;

  // peripheral slot numbers (order is the output bit order)
  localparam int PF_WKUP  = 0;
  localparam int PF_TIM0  = 1;
  localparam int PF_RADIO = 2;
  localparam int PF_USB   = 4;
  localparam int PF_DMA   = 5;
  localparam int PF_TIM1  = 6;
  localparam int PF_TIM2  = 7;
endpackage

// File: rtl/pf_regbank.sv
module pf_regbank
  import pf_pkg::*;
#(
  parameter int NUM = PF_NUM,
  parameter int DW  = PF_DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PF_AW-1:0] addr,
  input  logic [DW-1:0]    wdata,
  output logic [NUM-1:0]   prog_state,
  output logic             dbg_en,
  output logic [DW-1:0]    rdata
);
  localparam int PAIR_W = 2 * NUM;

  logic [NUM-1:0] set_mask;
  logic [NUM-1:0] clr_mask;
  logic           cfg_we;

  // decode the write into set and clear masks
  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    cfg_we   = 1'b0;
    if (wr_en) begin
      unique case (pf_addr_e'(addr))
        PF_A_SET:  set_mask = wdata[NUM-1:0];
        PF_A_CLR:  clr_mask = wdata[NUM-1:0];
        PF_A_CFG:  cfg_we   = 1'b1;
        PF_A_BOTH: begin
          set_mask = wdata[NUM-1:0];
          clr_mask = wdata[PAIR_W-1:NUM];
        end
      endcase
    end
  end

  // one flop per peripheral; set takes priority over clear
  for (genvar i = 0; i < NUM; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           prog_state[i] <= 1'b0;
      else if (set_mask[i]) prog_state[i] <= 1'b1;
      else if (clr_mask[i]) prog_state[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dbg_en <= 1'b1;
    else if (cfg_we) dbg_en <= wdata[0];
  end

  // read mux
  always_comb begin
    rdata = '0;
    unique case (pf_addr_e'(addr))
      PF_A_SET, PF_A_CLR: rdata[NUM-1:0]    = prog_state;
      PF_A_CFG:           rdata[0]          = dbg_en;
      PF_A_BOTH:          rdata[PAIR_W-1:0] = {prog_state, prog_state};
    endcase
  end
endmodule

// File: rtl/pf_freeze_mux.sv
module pf_freeze_mux
  import pf_pkg::*;
#(
  parameter int NUM      = PF_NUM,
  parameter int WDOG_IDX = PF_WDOG
) (
  input  logic [NUM-1:0] prog_state,
  input  logic           dbg_en,
  input  logic           halt,
  input  logic           wdog_rst_mode,
  output logic [NUM-1:0] freeze
);
  logic halt_all;
  assign halt_all = halt & dbg_en;

  for (genvar i = 0; i < NUM; i++) begin : g_slot
    if (i == WDOG_IDX) begin : g_wdog
      // halt always stops the watchdog; software only in interrupt mode
      assign freeze[i] = halt | (prog_state[i] & ~wdog_rst_mode);
    end else begin : g_plain
      assign freeze[i] = prog_state[i] | halt_all;
    end
  end
endmodule

// File: rtl/periph_freeze_ctrl.sv
module periph_freeze_ctrl
  import pf_pkg::*;
#(
  parameter int NUM      = PF_NUM,
  parameter int WDOG_IDX = PF_WDOG,
  parameter int DW       = PF_DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [PF_AW-1:0] reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             dbg_halt,
  input  logic             wdog_rst_mode,
  output logic [NUM-1:0]   freeze
);
  logic [NUM-1:0] prog_state;
  logic           dbg_en;

  pf_regbank #(.NUM(NUM), .DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .prog_state (prog_state),
    .dbg_en     (dbg_en),
    .rdata      (reg_rdata)
  );

  pf_freeze_mux #(.NUM(NUM), .WDOG_IDX(WDOG_IDX)) u_mux (
    .prog_state    (prog_state),
    .dbg_en        (dbg_en),
    .halt          (dbg_halt),
    .wdog_rst_mode (wdog_rst_mode),
    .freeze        (freeze)
  );
endmodule

// File: rtl/pf_checker.sv
module pf_checker
  import pf_pkg::*;
#(
  parameter int NUM      = PF_NUM,
  parameter int WDOG_IDX = PF_WDOG,
  parameter int DW       = PF_DW
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr,
  input logic [PF_AW-1:0] addr,
  input logic [DW-1:0]    wdata,
  input logic [NUM-1:0]   prog,
  input logic             dbg_en,
  input logic             halt,
  input logic             rst_mode,
  input logic [NUM-1:0]   frz
);
  // R2
  set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == PF_A_SET) |=> ((prog & $past(wdata[NUM-1:0])) == $past(wdata[NUM-1:0])));

  // R3
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == PF_A_CLR) |=> ((prog & $past(wdata[NUM-1:0])) == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(prog) && $stable(dbg_en));

  // R5
  both_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == PF_A_BOTH) |=> ((prog & $past(wdata[NUM-1:0])) == $past(wdata[NUM-1:0])));

  // R5
  both_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == PF_A_BOTH)
      |=> ((prog & $past(wdata[2*NUM-1:NUM] & ~wdata[NUM-1:0])) == '0));

  // R11
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == PF_A_CFG) |=> (dbg_en == $past(wdata[0])));

  // R6
  halt_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && dbg_en) |-> (&frz));

  // R8
  wdog_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> frz[WDOG_IDX]);

  // R9
  wdog_mode_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && rst_mode) |-> !frz[WDOG_IDX]);
endmodule

bind periph_freeze_ctrl pf_checker #(.NUM(NUM), .WDOG_IDX(WDOG_IDX), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr       (reg_wr),
  .addr     (reg_addr),
  .wdata    (reg_wdata),
  .prog     (prog_state),
  .dbg_en   (dbg_en),
  .halt     (dbg_halt),
  .rst_mode (wdog_rst_mode),
  .frz      (freeze)
);

// File: tb/tb_periph_freeze_ctrl.sv
`timescale 1ns/1ps
module tb_periph_freeze_ctrl;
  localparam int WD = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        dbg_halt = 1'b0;
  logic        wdog_rst_mode = 1'b0;
  logic [7:0]  freeze;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  periph_freeze_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbg_halt(dbg_halt),
    .wdog_rst_mode(wdog_rst_mode), .freeze(freeze)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [15:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  function automatic logic [7:0] exp_frz(input logic [7:0] p, input logic h,
                                        input logic d, input logic m);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = (i == WD) ? (h | (p[i] & ~m)) : (p[i] | (h & d));
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] st, sm, cm, ex;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk("R1 state", 2'd0, 16'h0000);
    rd_chk("R1 cfg", 2'd2, 16'h0001);
    chk("R1 freeze", {8'h0, freeze}, 16'h0000);

    // R2 set accumulates, zeros ignored
    wr(2'd0, 16'h0005);
    wr(2'd0, 16'h0030);
    rd_chk("R2 set accumulate", 2'd0, 16'h0035);
    wr(2'd0, 16'h0000);
    rd_chk("R2 zero set", 2'd0, 16'h0035);
    // R3 clear, zeros ignored, readback via clear address (R4)
    wr(2'd1, 16'h0004);
    rd_chk("R3 clear", 2'd1, 16'h0031);
    wr(2'd1, 16'h0000);
    rd_chk("R3 zero clear", 2'd1, 16'h0031);
    rd_chk("R4 pair read", 2'd3, 16'h3131);
    // R11 config write
    wr(2'd2, 16'hFFFE);
    rd_chk("R11 cfg low", 2'd2, 16'h0000);
    wr(2'd2, 16'h0001);
    rd_chk("R11 cfg high", 2'd2, 16'h0001);

    // R5 combined set+clear sweep
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        st = 8'(a * 37 + b * 11);
        sm = 8'(a * 17) & 8'(b * 5 + 3);
        cm = 8'(b * 17) | 8'(a);
        ex = (st & ~cm) | sm;
        wr(2'd1, 16'h00FF);
        wr(2'd0, {8'h00, st});
        wr(2'd3, {cm, sm});
        rd_chk("R5 combined", 2'd3, {ex, ex});
      end
    end

    // main sweep: every state x halt x cfg x mode
    for (int p = 0; p < 256; p++) begin
      wr(2'd1, 16'h00FF);
      wr(2'd0, 16'(p));
      rd_chk((p % 2) ? "R4 read clr addr" : "R4 read set addr", 2'(p % 2), 16'(p));
      for (int d = 0; d < 2; d++) begin
        wr(2'd2, 16'(d));
        for (int h = 0; h < 2; h++) begin
          for (int m = 0; m < 2; m++) begin
            dbg_halt = h[0]; wdog_rst_mode = m[0];
            #1;
            ex = exp_frz(8'(p), h[0], d[0], m[0]);
            chk(h ? "R8 wdog halted" : "R9 wdog mode", {15'h0, freeze[WD]}, {15'h0, ex[WD]});
            chk(h ? (d ? "R6 halt all" : "R7 halt follow") : "R10 no halt",
                {8'h0, freeze & 8'hF7}, {8'h0, ex & 8'hF7});
          end
        end
      end
      dbg_halt = 1'b0; wdog_rst_mode = 1'b0;
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule